// File: doc/BRIEF.md
# Multicycle Processor Phase Controller

This block sequences a 32-bit load/store processor. Each instruction moves through a set of phases, one phase per clock. The controller drives every strobe of a shared datapath in every phase: one memory port, one ALU, an instruction register and a register file.

The opcode field and the function field of the instruction register feed the block. The opcode is decoded in the second phase and picks the path for the rest of the instruction:

- Jumps and equality branches end after three clocks.
- Register-register operations and stores end after four.
- Loads take five.

A two-level ALU decode produces the 3-bit ALU operation. The phase logic emits a 2-bit intent (add, subtract, or "use the function field"). A secondary decoder turns that intent into the operation code, reading the function field only when the intent asks for it.

The controller is a Moore machine: every strobe depends only on the current phase. The opcode and function inputs must be stable from the decode phase until the instruction ends. The datapath supplies them from the instruction register, which is loaded at the end of the fetch phase.

Top module: `mc_phase_ctrl`

## Requirements
- R1: A low `rst_n` at a rising edge puts the controller in the fetch phase, from any phase, and the reset takes effect only at that edge. Fetch drives `mem_rd`=1, `ir_wr`=1, `pc_wr`=1, `addr_sel`=0 (PC), `alu_a_sel`=0 (PC), `alu_b_sel`=01 (constant 4), `pc_src`=00 (live ALU result) and `alu_ctl`=010 (add). Every other strobe is 0 in fetch.
- R2: The phase after fetch is always decode. Decode drives no write or read strobe, with `alu_a_sel`=0, `alu_b_sel`=11 (sign-extended offset shifted left by 2) and `alu_ctl`=010.
- R3: Opcode 0x23 (load) takes 5 phases: fetch, decode, then three more.
  - Address phase: `alu_a_sel`=1 (register A), `alu_b_sel`=10 (sign-extended offset), `alu_ctl`=010.
  - Read phase: `mem_rd`=1, `addr_sel`=1 (ALU output register).
  - Writeback phase: `rf_wr`=1, `dst_sel`=0 (rt, bits 20:16), `m2r_sel`=1 (memory data).
- R4: Opcode 0x2B (store) takes 4 phases: fetch, decode, the address phase of R3, then a phase with `mem_wr`=1 and `addr_sel`=1.
- R5: Opcode 0x00 (register-register) takes 4 phases: fetch, decode, then two more.
  - Execute phase: `alu_a_sel`=1, `alu_b_sel`=00 (register B), and `alu_ctl` taken from the function field.
  - Writeback phase: `rf_wr`=1, `dst_sel`=1 (rd, bits 15:11), `m2r_sel`=0 (ALU result).
- R6: Opcode 0x04 (branch-if-equal) takes 3 phases. The third drives `pc_wr_cond`=1, `pc_wr`=0, `pc_src`=01 (ALU output register, the target computed in decode), `alu_a_sel`=1, `alu_b_sel`=00 and `alu_ctl`=110 (subtract).
- R7: Opcode 0x02 (jump) takes 3 phases. The third drives `pc_wr`=1, `pc_src`=10 (jump target: PC bits 31:28 followed by instruction bits 25:0 shifted left by 2) and `pc_wr_cond`=0.
- R8: When the function field selects the operation, it maps to `alu_ctl` as follows. Any other function code gives 010.

  | Function code | Operation | `alu_ctl` |
  |---|---|---|
  | 0x20 | add | 010 |
  | 0x22 | subtract | 110 |
  | 0x24 | and | 000 |
  | 0x25 | or | 001 |
  | 0x2A | set-less-than | 111 |

- R9: Any opcode other than those in R3 to R7 returns the controller to fetch right after decode. No register-file, memory or PC write is issued for it.
- R10: `mem_rd` and `mem_wr` are never 1 together, and `pc_wr` and `pc_wr_cond` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 6 | Instruction bits 31:26 from the instruction register |
| funct | input | 6 | Instruction bits 5:0 from the instruction register |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write qualified by the ALU zero flag |
| addr_sel | output | 1 | Memory address source: 0 PC, 1 ALU output register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register load |
| rf_wr | output | 1 | Register file write |
| dst_sel | output | 1 | Destination: 1 rd (15:11), 0 rt (20:16) |
| m2r_sel | output | 1 | Write data: 1 memory data register, 0 ALU output register |
| alu_a_sel | output | 1 | ALU A: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B: 00 reg B, 01 constant 4, 10 offset, 11 offset shifted by 2 |
| pc_src | output | 2 | PC source: 00 ALU result, 01 ALU output register, 10 jump target |
| alu_ctl | output | 3 | ALU operation code |

## Verification
A wrong phase register shows at the ports in the same clock, because every strobe is a pure function of the phase. A skipped or extra phase therefore appears at once as a wrong strobe vector, and one clock later as a misplaced fetch pattern. The bench compares the full strobe vector in every clock of every instruction class. It includes a reset that arrives mid-load and unknown opcodes and function codes, so a wrong branch in the decode or a wrong field in the secondary ALU decode is seen within the instruction that exercises it.

// File: rtl/mc_phase_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the multicycle phase controller.
// Assumes a 32-bit instruction with a 6-bit opcode and 6-bit function field.
package mc_phase_pkg;
    localparam int OP_W   = 6;
    localparam int FN_W   = 6;
    localparam int AOP_W  = 2;
    localparam int ALUC_W = 3;
    localparam int SEL_W  = 2;

    localparam logic [OP_W-1:0] OPC_REG   = 6'h00;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OP_W-1:0] OPC_JUMP  = 6'h02;

    localparam logic [FN_W-1:0] FN_ADD = 6'h20;
    localparam logic [FN_W-1:0] FN_SUB = 6'h22;
    localparam logic [FN_W-1:0] FN_AND = 6'h24;
    localparam logic [FN_W-1:0] FN_OR  = 6'h25;
    localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

    localparam logic [ALUC_W-1:0] ALU_AND = 3'b000;
    localparam logic [ALUC_W-1:0] ALU_OR  = 3'b001;
    localparam logic [ALUC_W-1:0] ALU_ADD = 3'b010;
    localparam logic [ALUC_W-1:0] ALU_SUB = 3'b110;
    localparam logic [ALUC_W-1:0] ALU_SLT = 3'b111;

    localparam logic [AOP_W-1:0] AOP_ADD  = 2'b00;
    localparam logic [AOP_W-1:0] AOP_SUB  = 2'b01;
    localparam logic [AOP_W-1:0] AOP_FUNC = 2'b10;

    localparam logic [SEL_W-1:0] BSEL_REG    = 2'b00;
    localparam logic [SEL_W-1:0] BSEL_FOUR   = 2'b01;
    localparam logic [SEL_W-1:0] BSEL_IMM    = 2'b10;
    localparam logic [SEL_W-1:0] BSEL_IMM_SH = 2'b11;

    localparam logic [SEL_W-1:0] PCS_ALU    = 2'b00;
    localparam logic [SEL_W-1:0] PCS_ALUOUT = 2'b01;
    localparam logic [SEL_W-1:0] PCS_JUMP   = 2'b10;

    typedef enum logic [3:0] {
        PH_FETCH, PH_DECODE, PH_ADDR, PH_LD_MEM, PH_LD_WB,
        PH_ST_MEM, PH_R_EXE, PH_R_WB, PH_BRANCH, PH_JUMP
    } phase_t;

    typedef struct packed {
        logic             pc_wr;
        logic             pc_wr_cond;
        logic             addr_sel;
        logic             mem_rd;
        logic             mem_wr;
        logic             ir_wr;
        logic             rf_wr;
        logic             dst_sel;
        logic             m2r_sel;
        logic             alu_a_sel;
        logic [SEL_W-1:0] alu_b_sel;
        logic [SEL_W-1:0] pc_src;
        logic [AOP_W-1:0] alu_op;
    } strobes_t;
endpackage

// File: rtl/mc_phase_fsm.sv
`timescale 1ns/1ps
// Phase register and next-phase logic.
// Assumes opcode is stable from the decode phase to the end of the instruction.
module mc_phase_fsm
    import mc_phase_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] opcode,
    output phase_t          phase
);
    phase_t phase_nxt;

    // Choose the following phase from the current one and the opcode.
    always_comb begin
        phase_nxt = PH_FETCH;
        case (phase)
            PH_FETCH:  phase_nxt = PH_DECODE;
            PH_DECODE: begin
                case (opcode)
                    OPC_REG:             phase_nxt = PH_R_EXE;
                    OPC_LOAD, OPC_STORE: phase_nxt = PH_ADDR;
                    OPC_BEQ:             phase_nxt = PH_BRANCH;
                    OPC_JUMP:            phase_nxt = PH_JUMP;
                    default:             phase_nxt = PH_FETCH;
                endcase
            end
            PH_ADDR: begin
                if (opcode == OPC_LOAD)       phase_nxt = PH_LD_MEM;
                else if (opcode == OPC_STORE) phase_nxt = PH_ST_MEM;
                else                          phase_nxt = PH_FETCH;
            end
            PH_LD_MEM: phase_nxt = PH_LD_WB;
            PH_R_EXE:  phase_nxt = PH_R_WB;
            default:   phase_nxt = PH_FETCH;
        endcase
    end

    // Hold the phase; synchronous reset returns to fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_FETCH;
        else        phase <= phase_nxt;
    end

    AST_DECODE_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_FETCH |=> phase == PH_DECODE); // R2
    AST_LOAD_WB_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_LD_MEM |=> phase == PH_LD_WB); // R3
    AST_REG_WB_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_R_EXE |=> phase == PH_R_WB); // R5
    AST_UNKNOWN_REFETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DECODE && opcode != OPC_REG && opcode != OPC_LOAD &&
         opcode != OPC_STORE && opcode != OPC_BEQ && opcode != OPC_JUMP)
        |=> phase == PH_FETCH); // R9
endmodule

// File: rtl/mc_strobe_gen.sv
`timescale 1ns/1ps
// Moore output decode: maps each phase to its datapath strobes and ALU intent.
// Assumes strobes not named in a phase are inactive (0) in that phase.
module mc_strobe_gen
    import mc_phase_pkg::*;
(
    input  phase_t   phase,
    output strobes_t strb
);
    // Drive the strobe set for the current phase.
    always_comb begin
        strb = '0;
        strb.alu_op = AOP_ADD;
        case (phase)
            PH_FETCH: begin
                strb.mem_rd    = 1'b1;
                strb.ir_wr     = 1'b1;
                strb.pc_wr     = 1'b1;
                strb.alu_b_sel = BSEL_FOUR;
                strb.pc_src    = PCS_ALU;
            end
            PH_DECODE: strb.alu_b_sel = BSEL_IMM_SH;
            PH_ADDR: begin
                strb.alu_a_sel = 1'b1;
                strb.alu_b_sel = BSEL_IMM;
            end
            PH_LD_MEM: begin
                strb.mem_rd   = 1'b1;
                strb.addr_sel = 1'b1;
            end
            PH_LD_WB: begin
                strb.rf_wr   = 1'b1;
                strb.m2r_sel = 1'b1;
            end
            PH_ST_MEM: begin
                strb.mem_wr   = 1'b1;
                strb.addr_sel = 1'b1;
            end
            PH_R_EXE: begin
                strb.alu_a_sel = 1'b1;
                strb.alu_b_sel = BSEL_REG;
                strb.alu_op    = AOP_FUNC;
            end
            PH_R_WB: begin
                strb.rf_wr   = 1'b1;
                strb.dst_sel = 1'b1;
            end
            PH_BRANCH: begin
                strb.alu_a_sel  = 1'b1;
                strb.alu_b_sel  = BSEL_REG;
                strb.alu_op     = AOP_SUB;
                strb.pc_wr_cond = 1'b1;
                strb.pc_src     = PCS_ALUOUT;
            end
            PH_JUMP: begin
                strb.pc_wr  = 1'b1;
                strb.pc_src = PCS_JUMP;
            end
            default: strb = '0;
        endcase
    end
endmodule

// File: rtl/mc_alu_decode.sv
`timescale 1ns/1ps
// Secondary ALU decode: combines the 2-bit intent with the function field.
// Assumes unknown function codes fall back to add.
module mc_alu_decode
    import mc_phase_pkg::*;
(
    input  logic [AOP_W-1:0]  alu_op,
    input  logic [FN_W-1:0]   funct,
    output logic [ALUC_W-1:0] alu_ctl
);
    // Resolve the ALU operation code from the intent and function field.
    always_comb begin
        case (alu_op)
            AOP_ADD: alu_ctl = ALU_ADD;
            AOP_SUB: alu_ctl = ALU_SUB;
            default: begin
                case (funct)
                    FN_SUB:  alu_ctl = ALU_SUB;
                    FN_AND:  alu_ctl = ALU_AND;
                    FN_OR:   alu_ctl = ALU_OR;
                    FN_SLT:  alu_ctl = ALU_SLT;
                    default: alu_ctl = ALU_ADD;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/mc_phase_ctrl.sv
`timescale 1ns/1ps
// Top of the multicycle controller: phase FSM, strobe decode and ALU decode.
// Assumes opcode/funct come from the instruction register loaded in fetch.
module mc_phase_ctrl
    import mc_phase_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   opcode,
    input  logic [FN_W-1:0]   funct,
    output logic              pc_wr,
    output logic              pc_wr_cond,
    output logic              addr_sel,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              ir_wr,
    output logic              rf_wr,
    output logic              dst_sel,
    output logic              m2r_sel,
    output logic              alu_a_sel,
    output logic [SEL_W-1:0]  alu_b_sel,
    output logic [SEL_W-1:0]  pc_src,
    output logic [ALUC_W-1:0] alu_ctl
);
    phase_t   phase;
    strobes_t strb;

    mc_phase_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (opcode),
        .phase  (phase)
    );

    mc_strobe_gen u_strb (
        .phase (phase),
        .strb  (strb)
    );

    mc_alu_decode u_alu (
        .alu_op  (strb.alu_op),
        .funct   (funct),
        .alu_ctl (alu_ctl)
    );

    // Fan the strobe bundle out to the ports.
    always_comb begin
        pc_wr      = strb.pc_wr;
        pc_wr_cond = strb.pc_wr_cond;
        addr_sel   = strb.addr_sel;
        mem_rd     = strb.mem_rd;
        mem_wr     = strb.mem_wr;
        ir_wr      = strb.ir_wr;
        rf_wr      = strb.rf_wr;
        dst_sel    = strb.dst_sel;
        m2r_sel    = strb.m2r_sel;
        alu_a_sel  = strb.alu_a_sel;
        alu_b_sel  = strb.alu_b_sel;
        pc_src     = strb.pc_src;
    end

    AST_RESET_TO_FETCH: assert property (@(posedge clk)
        !rst_n |=> (ir_wr && mem_rd && pc_wr && !addr_sel)); // R1
    AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R10
    AST_PC_WRITE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pc_wr && pc_wr_cond)); // R10
    AST_BRANCH_SUBTRACTS: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr_cond |-> (alu_ctl == ALU_SUB && pc_src == PCS_ALUOUT)); // R6
    AST_RD_WB_AFTER_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr && dst_sel) |-> $past(alu_a_sel && alu_b_sel == BSEL_REG)); // R5
    AST_STORE_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(alu_b_sel == BSEL_IMM)); // R4
endmodule

// File: tb/mc_phase_ctrl_tb.sv
`timescale 1ns/1ps
module mc_phase_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'h3F;
    logic [5:0] funct = 6'h00;
    logic       pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr;
    logic       rf_wr, dst_sel, m2r_sel, alu_a_sel;
    logic [1:0] alu_b_sel, pc_src;
    logic [2:0] alu_ctl;

    int n_checks = 0;
    int n_fails  = 0;

    logic [16:0] q_vec[$];
    string       q_req[$];

    always #2.5 clk = ~clk;

    mc_phase_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .addr_sel(addr_sel),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .rf_wr(rf_wr),
        .dst_sel(dst_sel), .m2r_sel(m2r_sel), .alu_a_sel(alu_a_sel),
        .alu_b_sel(alu_b_sel), .pc_src(pc_src), .alu_ctl(alu_ctl)
    );

    // Pack a strobe set: pcw,pcc,ad,mr,mw,irw,rfw,dst,m2r,asel,bsel,psrc,alu
    function automatic logic [16:0] mk(input logic pcw, pcc, ad, mr, mw, irw,
        rfw, dst, m2r, asel, input logic [1:0] bsel, psrc, input logic [2:0] alu);
        return {pcw, pcc, ad, mr, mw, irw, rfw, dst, m2r, asel, bsel, psrc, alu};
    endfunction

    function automatic logic [16:0] observed();
        return {pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, rf_wr,
                dst_sel, m2r_sel, alu_a_sel, alu_b_sel, pc_src, alu_ctl};
    endfunction

    // Expected per-phase vectors taken from the requirement text
    localparam logic [16:0] V_FETCH = {1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'b01,2'b00,3'b010};
    localparam logic [16:0] V_DEC   = {10'b0, 2'b11, 2'b00, 3'b010};
    localparam logic [16:0] V_ADDR  = {9'b0, 1'b1, 2'b10, 2'b00, 3'b010};
    localparam logic [16:0] V_LDMEM = {2'b00, 1'b1, 1'b1, 6'b0, 2'b00, 2'b00, 3'b010};
    localparam logic [16:0] V_LDWB  = {6'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 3'b010};
    localparam logic [16:0] V_STMEM = {2'b00, 1'b1, 1'b0, 1'b1, 5'b0, 2'b00, 2'b00, 3'b010};
    localparam logic [16:0] V_RWB   = {6'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 3'b010};
    localparam logic [16:0] V_BR    = {1'b0, 1'b1, 7'b0, 1'b1, 2'b00, 2'b01, 3'b110};
    localparam logic [16:0] V_JMP   = {1'b1, 9'b0, 2'b00, 2'b10, 3'b010};

    function automatic logic [2:0] exp_alu(input logic [5:0] fn);
        case (fn)
            6'h20:   return 3'b010;
            6'h22:   return 3'b110;
            6'h24:   return 3'b000;
            6'h25:   return 3'b001;
            6'h2A:   return 3'b111;
            default: return 3'b010;
        endcase
    endfunction

    task automatic push(input logic [16:0] v, input string r);
        q_vec.push_back(v);
        q_req.push_back(r);
    endtask

    task automatic check(input string r, input logic [16:0] act, input logic [16:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%b expected=%b", r, act, exp);
        end
    endtask

    // Driver: called just after the edge that enters fetch; queues the expected phases.
    task automatic issue(input logic [5:0] op, input logic [5:0] fn, input string r);
        int n;
        opcode = op;
        funct  = fn;
        push(V_FETCH, {r, " fetch R1"});
        push(V_DEC, {r, " decode R2"});
        case (op)
            6'h23: begin push(V_ADDR, {r, " R3"}); push(V_LDMEM, {r, " R3"}); push(V_LDWB, {r, " R3"}); n = 5; end
            6'h2B: begin push(V_ADDR, {r, " R4"}); push(V_STMEM, {r, " R4"}); n = 4; end
            6'h00: begin
                push({9'b0, 1'b1, 2'b00, 2'b00, exp_alu(fn)}, {r, " R5 R8"});
                push(V_RWB, {r, " R5"});
                n = 4;
            end
            6'h04: begin push(V_BR, {r, " R6"}); n = 3; end
            6'h02: begin push(V_JMP, {r, " R7"}); n = 3; end
            default: n = 2;
        endcase
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Monitor: compare the strobes in mid-cycle against the next queued item.
    always @(negedge clk) begin
        if (q_vec.size() > 0) begin
            check(q_req.pop_front(), observed(), q_vec.pop_front());
        end
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        // R1: reset state seen at the ports
        @(posedge clk);
        @(negedge clk);
        check("R1 reset state", observed(), V_FETCH);
        @(posedge clk);
        #1;
        rst_n = 1'b1;

        issue(6'h23, 6'h00, "load");
        issue(6'h2B, 6'h00, "store");
        issue(6'h00, 6'h20, "add");
        issue(6'h00, 6'h22, "sub");
        issue(6'h00, 6'h24, "and");
        issue(6'h00, 6'h25, "or");
        issue(6'h00, 6'h2A, "slt");
        issue(6'h00, 6'h27, "unknown funct R8");
        issue(6'h04, 6'h2A, "beq");
        issue(6'h02, 6'h00, "jump");
        issue(6'h3F, 6'h20, "unknown op R9");
        issue(6'h08, 6'h00, "unknown op2 R9");

        // R1: reset arriving mid-load, in the address phase
        opcode = 6'h23;
        funct  = 6'h00;
        push(V_FETCH, "midreset fetch R1");
        push(V_DEC, "midreset decode R2");
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b0;
        push(V_ADDR, "sync reset waits for edge R1");
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        issue(6'h00, 6'h25, "after reset R1");

        issue(6'h02, 6'h00, "jump b2b");
        issue(6'h04, 6'h00, "beq b2b");
        issue(6'h23, 6'h22, "load b2b");

        @(negedge clk);
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule